// File: doc/BRIEF.md
# EEPROM ownership arbiter

This block settles which of two register-mapped hosts may issue commands to a shared EEPROM command engine. One host is the network-side master ("net host"); the other is the local application processor ("local host"). The net host alone can write a grant bit; the local host alone can write a claim bit. The local host owns the engine whenever either bit is set, and the net host owns it only when both are clear. The normal hand-over is: the net host grants, the local host claims, the local host works and then unclaims, and the net host withdraws its grant.

A stuck local host can be overridden. A net-host write of the force code (0x02) to the grant register clears the claim bit on that edge. Following it with a write of 0x00 leaves both bits clear, so the net host owns the engine again. The block drives an owner select for the command multiplexer and forwards the owner's command strobe. It drops a strobe from the other host and flags the denial. It never switches owner while the command engine reports busy.

Top module: `eep_own_arb`

## Requirements
- R1: After reset, grant and claim are 0, the net host owns the engine (`owner_local`=0), `access_denied`=0, and both read ports return 0.
- R2: A net-host write to the grant address (default 0) loads the grant bit from data bit 0 on that clock edge. A local-host write to the grant address changes nothing.
- R3: A local-host write to the claim address (default 1) with data bit 0 = 1 sets the claim bit only if the grant bit is already 1. A net-host write to the claim address changes nothing.
- R4: A local-host write to the claim address with data bit 0 = 0 clears the claim bit whatever the grant bit is.
- R5: While busy is low, `owner_local` becomes (grant OR claim) one clock after the bits change. 1 means the local host owns the engine.
- R6: A net-host write of exactly 0x02 to the grant address clears the claim bit on that edge, and the grant bit takes bit 0 of the value, which is 0. A following write of 0x00 leaves the net host as owner. No other value touches the claim bit.
- R7: Each host's read data is combinational. It gives {0…0, grant} at the grant address, {0…0, claim} at the claim address, and 0 at any other address.
- R8: `eep_cmd_valid` follows the owner's command strobe in the same cycle. A strobe from the non-owner is dropped, and `access_denied` is high for exactly the following cycle.
- R9: While `cmd_busy` is high, `owner_local` holds its value. A change requested meanwhile shows on the first cycle after busy is sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| net_wr_en | input | 1 | Net-host register write strobe |
| net_addr | input | ADDR_W | Net-host register address |
| net_wdata | input | DATA_W | Net-host write data |
| net_rdata | output | DATA_W | Net-host read data |
| net_cmd_req | input | 1 | Net-host EEPROM command strobe |
| loc_wr_en | input | 1 | Local-host register write strobe |
| loc_addr | input | ADDR_W | Local-host register address |
| loc_wdata | input | DATA_W | Local-host write data |
| loc_rdata | output | DATA_W | Local-host read data |
| loc_cmd_req | input | 1 | Local-host EEPROM command strobe |
| cmd_busy | input | 1 | Command engine busy |
| owner_local | output | 1 | Owner select: 1 = local host, 0 = net host |
| eep_cmd_valid | output | 1 | Command strobe forwarded from the owner |
| access_denied | output | 1 | One-cycle pulse after a dropped strobe |

## Verification
The bench writes all 256 values to the grant register while the claim bit is set. A design that matched the force code loosely, for example on bit 1 alone, would drop the claim on 0x03 or 0xFF. A design that ignored the code would leave a stuck local host in control.

The bench runs a local claim against every grant state and also tries writes to the wrong register from each host. A missing grant gate would let the local host seize the engine unasked. It drives all four strobe pairs under both owners, which would expose a swapped multiplexer or a denial pulse that lasts more than one cycle. Finally, the bench requests a grant while busy is high. A design that ignored busy would switch owner in the middle of a transfer.

// File: rtl/eep_arb_pkg.sv
package eep_arb_pkg;

    typedef enum logic {
        OWN_NET = 1'b0,
        OWN_LOC = 1'b1
    } owner_e;

    typedef struct packed {
        logic grant;
        logic claim;
    } own_bits_t;

    typedef struct packed {
        owner_e owner;
    } hold_t;

    typedef struct packed {
        logic deny;
    } gate_t;

endpackage

// File: rtl/eep_own_regs.sv
module eep_own_regs
    import eep_arb_pkg::*;
#(
    parameter int unsigned             ADDR_W     = 2,
    parameter int unsigned             DATA_W     = 8,
    parameter logic [ADDR_W-1:0]       GRANT_ADDR = '0,
    parameter logic [ADDR_W-1:0]       CLAIM_ADDR = ADDR_W'(1),
    parameter logic [DATA_W-1:0]       FORCE_CODE = DATA_W'(2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              net_wr_en,
    input  logic [ADDR_W-1:0] net_addr,
    input  logic [DATA_W-1:0] net_wdata,
    input  logic              loc_wr_en,
    input  logic [ADDR_W-1:0] loc_addr,
    input  logic [DATA_W-1:0] loc_wdata,
    output own_bits_t         bits_o
);

    own_bits_t bits_d, bits_q;
    logic      net_grant_wr;
    logic      loc_claim_wr;
    logic      unused_loc_hi;

    assign unused_loc_hi = ^loc_wdata[DATA_W-1:1];

    always_comb begin
        bits_d       = bits_q;
        net_grant_wr = net_wr_en && (net_addr == GRANT_ADDR);
        loc_claim_wr = loc_wr_en && (loc_addr == CLAIM_ADDR);

        if (net_grant_wr) begin
            bits_d.grant = net_wdata[0];
        end

        if (loc_claim_wr) begin
            if (!loc_wdata[0]) begin
                bits_d.claim = 1'b0;
            end else if (bits_q.grant) begin
                bits_d.claim = 1'b1;
            end
        end

        // force code from the net host overrides any same-cycle claim
        if (net_grant_wr && (net_wdata == FORCE_CODE)) begin
            bits_d.claim = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else begin
            bits_q <= bits_d;
        end
    end

    assign bits_o = bits_q;

endmodule

// File: rtl/eep_owner_hold.sv
module eep_owner_hold
    import eep_arb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      busy,
    input  own_bits_t bits,
    output owner_e    owner_o
);

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!busy) begin
            st_d.owner = (bits.grant || bits.claim) ? OWN_LOC : OWN_NET;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{owner: OWN_NET};
        end else begin
            st_q <= st_d;
        end
    end

    assign owner_o = st_q.owner;

endmodule

// File: rtl/eep_cmd_gate.sv
module eep_cmd_gate
    import eep_arb_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  owner_e owner,
    input  logic   net_req,
    input  logic   loc_req,
    output logic   cmd_valid,
    output logic   deny_o
);

    gate_t st_d, st_q;

    always_comb begin
        if (owner == OWN_LOC) begin
            cmd_valid   = loc_req;
            st_d.deny   = net_req;
        end else begin
            cmd_valid   = net_req;
            st_d.deny   = loc_req;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign deny_o = st_q.deny;

endmodule

// File: rtl/eep_rd_port.sv
module eep_rd_port
    import eep_arb_pkg::*;
#(
    parameter int unsigned       ADDR_W     = 2,
    parameter int unsigned       DATA_W     = 8,
    parameter logic [ADDR_W-1:0] GRANT_ADDR = '0,
    parameter logic [ADDR_W-1:0] CLAIM_ADDR = ADDR_W'(1)
) (
    input  logic [ADDR_W-1:0] addr,
    input  own_bits_t         bits,
    output logic [DATA_W-1:0] rdata
);

    always_comb begin
        rdata = '0;
        if (addr == GRANT_ADDR) begin
            rdata[0] = bits.grant;
        end else if (addr == CLAIM_ADDR) begin
            rdata[0] = bits.claim;
        end
    end

endmodule

// File: rtl/eep_own_arb.sv
module eep_own_arb
    import eep_arb_pkg::*;
#(
    parameter int unsigned       ADDR_W     = 2,
    parameter int unsigned       DATA_W     = 8,
    parameter logic [ADDR_W-1:0] GRANT_ADDR = '0,
    parameter logic [ADDR_W-1:0] CLAIM_ADDR = ADDR_W'(1),
    parameter logic [DATA_W-1:0] FORCE_CODE = DATA_W'(2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              net_wr_en,
    input  logic [ADDR_W-1:0] net_addr,
    input  logic [DATA_W-1:0] net_wdata,
    output logic [DATA_W-1:0] net_rdata,
    input  logic              net_cmd_req,
    input  logic              loc_wr_en,
    input  logic [ADDR_W-1:0] loc_addr,
    input  logic [DATA_W-1:0] loc_wdata,
    output logic [DATA_W-1:0] loc_rdata,
    input  logic              loc_cmd_req,
    input  logic              cmd_busy,
    output logic              owner_local,
    output logic              eep_cmd_valid,
    output logic              access_denied
);

    localparam int unsigned N_HOST = 2;

    own_bits_t         bits;
    owner_e            owner;
    logic              grant_bit;
    logic              claim_bit;
    logic [ADDR_W-1:0] rd_addr [N_HOST];
    logic [DATA_W-1:0] rd_data [N_HOST];

    eep_own_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .GRANT_ADDR(GRANT_ADDR), .CLAIM_ADDR(CLAIM_ADDR),
        .FORCE_CODE(FORCE_CODE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .net_wr_en(net_wr_en), .net_addr(net_addr), .net_wdata(net_wdata),
        .loc_wr_en(loc_wr_en), .loc_addr(loc_addr), .loc_wdata(loc_wdata),
        .bits_o(bits)
    );

    eep_owner_hold u_hold (
        .clk(clk), .rst_n(rst_n), .busy(cmd_busy),
        .bits(bits), .owner_o(owner)
    );

    eep_cmd_gate u_gate (
        .clk(clk), .rst_n(rst_n), .owner(owner),
        .net_req(net_cmd_req), .loc_req(loc_cmd_req),
        .cmd_valid(eep_cmd_valid), .deny_o(access_denied)
    );

    assign rd_addr[0] = net_addr;
    assign rd_addr[1] = loc_addr;

    for (genvar h = 0; h < N_HOST; h++) begin : g_rd
        eep_rd_port #(
            .ADDR_W(ADDR_W), .DATA_W(DATA_W),
            .GRANT_ADDR(GRANT_ADDR), .CLAIM_ADDR(CLAIM_ADDR)
        ) u_rd (
            .addr(rd_addr[h]), .bits(bits), .rdata(rd_data[h])
        );
    end

    assign net_rdata   = rd_data[0];
    assign loc_rdata   = rd_data[1];
    assign owner_local = (owner == OWN_LOC);
    assign grant_bit   = bits.grant;
    assign claim_bit   = bits.claim;

endmodule

// File: rtl/eep_own_arb_chk.sv
module eep_own_arb_chk #(
    parameter int unsigned       ADDR_W     = 2,
    parameter int unsigned       DATA_W     = 8,
    parameter logic [ADDR_W-1:0] GRANT_ADDR = '0,
    parameter logic [DATA_W-1:0] FORCE_CODE = DATA_W'(2)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              net_wr_en,
    input logic [ADDR_W-1:0] net_addr,
    input logic [DATA_W-1:0] net_wdata,
    input logic              net_cmd_req,
    input logic              loc_cmd_req,
    input logic              cmd_busy,
    input logic              owner_local,
    input logic              eep_cmd_valid,
    input logic              access_denied,
    input logic              grant_bit,
    input logic              claim_bit
);

    p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_busy |=> $stable(owner_local));

    p_claim_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(claim_bit) |-> $past(grant_bit));

    p_force_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (net_wr_en && (net_addr == GRANT_ADDR) && (net_wdata == FORCE_CODE))
        |=> !claim_bit);

    p_pass_owner_r8: assert property (@(posedge clk) disable iff (!rst_n)
        eep_cmd_valid |-> (owner_local ? loc_cmd_req : net_cmd_req));

    p_deny_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        access_denied |-> $past(owner_local ? net_cmd_req : loc_cmd_req));

    p_net_owner_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_busy && !grant_bit && !claim_bit) |=> !owner_local);

endmodule

bind eep_own_arb eep_own_arb_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .GRANT_ADDR(GRANT_ADDR), .FORCE_CODE(FORCE_CODE)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .net_wr_en(net_wr_en), .net_addr(net_addr), .net_wdata(net_wdata),
    .net_cmd_req(net_cmd_req), .loc_cmd_req(loc_cmd_req),
    .cmd_busy(cmd_busy), .owner_local(owner_local),
    .eep_cmd_valid(eep_cmd_valid), .access_denied(access_denied),
    .grant_bit(grant_bit), .claim_bit(claim_bit)
);

// File: tb/tb_eep_own_arb.sv
`timescale 1ns/1ps
module tb_eep_own_arb;

    localparam int ADDR_W = 2;
    localparam int DATA_W = 8;
    localparam logic [ADDR_W-1:0] GA = 2'd0;
    localparam logic [ADDR_W-1:0] CA = 2'd1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              net_wr_en = 1'b0;
    logic [ADDR_W-1:0] net_addr = '0;
    logic [DATA_W-1:0] net_wdata = '0;
    logic [DATA_W-1:0] net_rdata;
    logic              net_cmd_req = 1'b0;
    logic              loc_wr_en = 1'b0;
    logic [ADDR_W-1:0] loc_addr = '0;
    logic [DATA_W-1:0] loc_wdata = '0;
    logic [DATA_W-1:0] loc_rdata;
    logic              loc_cmd_req = 1'b0;
    logic              cmd_busy = 1'b0;
    logic              owner_local;
    logic              eep_cmd_valid;
    logic              access_denied;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    eep_own_arb dut (
        .clk(clk), .rst_n(rst_n),
        .net_wr_en(net_wr_en), .net_addr(net_addr), .net_wdata(net_wdata),
        .net_rdata(net_rdata), .net_cmd_req(net_cmd_req),
        .loc_wr_en(loc_wr_en), .loc_addr(loc_addr), .loc_wdata(loc_wdata),
        .loc_rdata(loc_rdata), .loc_cmd_req(loc_cmd_req),
        .cmd_busy(cmd_busy), .owner_local(owner_local),
        .eep_cmd_valid(eep_cmd_valid), .access_denied(access_denied)
    );

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic nw(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
        @(negedge clk);
        net_wr_en = 1'b1; net_addr = a; net_wdata = d;
        @(negedge clk);
        net_wr_en = 1'b0;
    endtask

    task automatic lw(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
        @(negedge clk);
        loc_wr_en = 1'b1; loc_addr = a; loc_wdata = d;
        @(negedge clk);
        loc_wr_en = 1'b0;
    endtask

    task automatic force_release();
        nw(GA, 8'h02);
        nw(GA, 8'h00);
        tick();
    endtask

    // reads grant through the net port and claim through the local port
    task automatic rd_bits(output int g, output int c);
        net_addr = GA; loc_addr = CA;
        #1;
        g = int'(net_rdata);
        c = int'(loc_rdata);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        int g, c;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        chk("R1 owner", owner_local, 0);
        chk("R1 deny", access_denied, 0);
        chk("R1 valid", eep_cmd_valid, 0);
        rd_bits(g, c);
        chk("R1 grant rd", g, 0);
        chk("R1 claim rd", c, 0);

        // R2/R3/R4/R5 sweep of grant x claim attempt
        for (int gi = 0; gi < 2; gi++) begin
            for (int ci = 0; ci < 2; ci++) begin
                force_release();
                nw(GA, DATA_W'(gi));
                lw(CA, DATA_W'(ci));
                tick();
                rd_bits(g, c);
                chk("R2 grant load", g, gi);
                chk("R3 claim gated", c, gi & ci);
                chk("R5 owner", owner_local, gi | (gi & ci));
                lw(CA, 8'h00);
                tick();
                rd_bits(g, c);
                chk("R4 claim clear", c, 0);
                chk("R5 owner after clear", owner_local, gi);
            end
        end

        // R2: local write to grant ignored; R3: net write to claim ignored
        force_release();
        lw(GA, 8'h01);
        tick();
        rd_bits(g, c);
        chk("R2 local grant write ignored", g, 0);
        chk("R2 owner unchanged", owner_local, 0);
        nw(GA, 8'h01);
        nw(CA, 8'h01);
        tick();
        rd_bits(g, c);
        chk("R3 net claim write ignored", c, 0);

        // R4: clear works with grant 0 and claim set
        lw(CA, 8'h01);
        nw(GA, 8'h00);
        lw(CA, 8'h00);
        tick();
        rd_bits(g, c);
        chk("R4 clear without grant", c, 0);

        // R6 exhaustive values to grant register with claim set
        for (int v = 0; v < 256; v++) begin
            nw(GA, 8'h01);
            lw(CA, 8'h01);
            nw(GA, v[7:0]);
            rd_bits(g, c);
            chk("R6 grant bit", g, v & 1);
            chk("R6 claim", c, (v == 2) ? 0 : 1);
        end
        nw(GA, 8'h01);
        lw(CA, 8'h01);
        tick();
        chk("R6 local owns before force", owner_local, 1);
        force_release();
        chk("R6 net owns after force", owner_local, 0);

        // R7 other addresses read zero in both ports
        nw(GA, 8'h01);
        lw(CA, 8'h01);
        for (int a = 0; a < 4; a++) begin
            net_addr = ADDR_W'(a); loc_addr = ADDR_W'(a);
            #1;
            chk("R7 net rd", int'(net_rdata), (a < 2) ? 1 : 0);
            chk("R7 loc rd", int'(loc_rdata), (a < 2) ? 1 : 0);
        end

        // R8 strobe sweep under both owners
        for (int own = 0; own < 2; own++) begin
            force_release();
            if (own == 1) begin
                nw(GA, 8'h01);
                tick();
            end
            chk("R8 owner setup", owner_local, own);
            for (int p = 0; p < 4; p++) begin
                @(negedge clk);
                net_cmd_req = p[0]; loc_cmd_req = p[1];
                #1;
                chk("R8 forward", eep_cmd_valid, own ? p[1] : p[0]);
                @(negedge clk);
                chk("R8 deny pulse", access_denied, own ? p[0] : p[1]);
                net_cmd_req = 1'b0; loc_cmd_req = 1'b0;
                @(negedge clk);
                chk("R8 deny one cycle", access_denied, 0);
            end
        end

        // R9 busy holds owner
        force_release();
        @(negedge clk);
        cmd_busy = 1'b1;
        nw(GA, 8'h01);
        repeat (3) tick();
        chk("R9 held during busy", owner_local, 0);
        cmd_busy = 1'b0;
        #1;
        chk("R9 still held at fall", owner_local, 0);
        tick();
        chk("R9 applied after busy", owner_local, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule